// File: doc/BRIEF.md
# Cluster Migration Power Sequencer

This block moves execution between two processor clusters in a system where only one cluster may run at any time. Each cluster has its own power domain. The block drives three controls for each cluster: a power enable, a reset hold and an isolation clamp. When a migrate command names the idle cluster, the block first brings that inbound cluster fully up. Only after that does it shut the outbound cluster down. Software still saves and restores processor state, controls snooping and moves interrupts. The block handles only the electrical ordering of the rails.

The inbound side goes through three steps. Power is enabled first. Reset is released once that cluster's power-good input is seen. After a programmable gap, the isolation clamp is removed. The block then waits for the inbound cluster's running input, which stands for software reporting that it is ready. Only then does the outbound side go down: reset is asserted, isolation is applied after a gap, and power is removed after a further gap. The `done` output pulses for one cycle when the sequence ends.

The command interface is a plain control pulse, with no valid/ready. `mig_req` is sampled only while `busy` is low. A pulse while `busy` is high is dropped, so the caller must wait for `busy` to go low before it issues the next command.

Top module: `cluster_migration_sequencer`

## Requirements
- R1: After reset, cluster 0 has power enabled, reset released and isolation off. Cluster 1 has power disabled, reset held and isolation on. `busy` and `done` are low.
- R2: A request accepted at a clock edge sets the inbound `pwr_en` and `busy` at that edge. The inbound `rst_hold` stays high until `pgood` of that cluster is sampled high, and it falls at that edge.
- R3: The inbound `iso_en` falls exactly G cycles after the inbound `rst_hold` falls. G is `step_delay` latched at acceptance, or 4 if `step_delay` is below 4.
- R4: No outbound control changes until `running` of the inbound cluster is sampled high. The outbound `rst_hold` rises at that edge. The inbound cluster is fully up at that time.
- R5: The outbound `iso_en` rises G cycles after the outbound `rst_hold` rises. The outbound `pwr_en` falls G cycles after that. Isolation is applied only while in reset, and power is removed only while isolated and in reset.
- R6: `done` is high for exactly one cycle, at the same edge where the outbound `pwr_en` falls. `busy` goes low at that edge.
- R7: A request whose target is the active cluster raises `done` at the next edge for one cycle. It changes no rail output and never raises `busy`.
- R8: A request made while `busy` is high has no effect. The rail outputs and the running sequence are unchanged.
- R9: Whenever `busy` is low, exactly one cluster has power on, reset released and isolation off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mig_req | input | 1 | Migrate command pulse, sampled while not busy |
| mig_target | input | 1 | Index of the cluster to migrate to |
| step_delay | input | DLY_W | Gap between rail steps in cycles (minimum 4 applied) |
| pgood | input | 2 | Power-good per cluster |
| running | input | 2 | Cluster-ready indication per cluster |
| pwr_en | output | 2 | Power enable per cluster |
| rst_hold | output | 2 | Reset held per cluster (1 = in reset) |
| iso_en | output | 2 | Isolation clamp per cluster (1 = clamped) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every rail output is registered. Each output therefore changes at the clock edge that samples its trigger (the request, `pgood` or `running`), or at the edge that ends a gap, which is exactly G edges after the step before it. The bench drives inputs and samples outputs on falling edges. It checks a triggered change at the first falling edge after the trigger was driven. It measures each gap by counting falling edges from the earlier change to the later one and compares the count with G. The same-target `done` is checked one falling edge after the request. Its drop is checked at the falling edge after that.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int NUM_CL = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PG,
    ST_GAP_UNISO,
    ST_WAIT_RUN,
    ST_GAP_ISO,
    ST_GAP_OFF
  } seq_state_t;

  typedef enum logic [2:0] {
    RAIL_HOLD,
    RAIL_PWR_ON,
    RAIL_UNRESET,
    RAIL_UNISO,
    RAIL_RESET,
    RAIL_ISO,
    RAIL_PWR_OFF
  } rail_cmd_t;
endpackage

// File: rtl/cms_gap_timer.sv
module cms_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cms_cluster_rail.sv
module cms_cluster_rail
  import cms_pkg::*;
#(
  parameter bit START_ON = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rail_cmd_t cmd,
  output logic      pwr_o,
  output logic      rst_o,
  output logic      iso_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_o <= START_ON;
      rst_o <= !START_ON;
      iso_o <= !START_ON;
    end else begin
      case (cmd)
        RAIL_PWR_ON:  pwr_o <= 1'b1;
        RAIL_UNRESET: rst_o <= 1'b0;
        RAIL_UNISO:   iso_o <= 1'b0;
        RAIL_RESET:   rst_o <= 1'b1;
        RAIL_ISO:     iso_o <= 1'b1;
        RAIL_PWR_OFF: pwr_o <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cluster_migration_sequencer.sv
module cluster_migration_sequencer
  import cms_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int MIN_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mig_req,
  input  logic             mig_target,
  input  logic [DLY_W-1:0] step_delay,
  input  logic [1:0]       pgood,
  input  logic [1:0]       running,
  output logic [1:0]       pwr_en,
  output logic [1:0]       rst_hold,
  output logic [1:0]       iso_en,
  output logic             busy,
  output logic             done
);
  localparam logic [DLY_W-1:0] MIN_GAP_V = DLY_W'(MIN_GAP);

  seq_state_t st_q, st_d;
  logic       active_q, in_q, in_idx, out_idx;
  logic       done_q;
  logic [DLY_W-1:0] gap_q;
  logic       accept, trivial, finish, tmr_load, tmr_expired;
  rail_cmd_t  in_cmd, out_cmd;
  rail_cmd_t  cl_cmd [NUM_CL];

  assign in_idx  = (st_q == ST_IDLE) ? mig_target : in_q;
  assign out_idx = !in_idx;

  always_comb begin
    st_d     = st_q;
    in_cmd   = RAIL_HOLD;
    out_cmd  = RAIL_HOLD;
    tmr_load = 1'b0;
    accept   = 1'b0;
    trivial  = 1'b0;
    finish   = 1'b0;
    case (st_q)
      ST_IDLE: if (mig_req) begin
        if (mig_target == active_q) trivial = 1'b1;
        else begin
          accept = 1'b1;
          in_cmd = RAIL_PWR_ON;
          st_d   = ST_WAIT_PG;
        end
      end
      ST_WAIT_PG: if (pgood[in_idx]) begin
        in_cmd   = RAIL_UNRESET;
        tmr_load = 1'b1;
        st_d     = ST_GAP_UNISO;
      end
      ST_GAP_UNISO: if (tmr_expired) begin
        in_cmd = RAIL_UNISO;
        st_d   = ST_WAIT_RUN;
      end
      ST_WAIT_RUN: if (running[in_idx]) begin
        out_cmd  = RAIL_RESET;
        tmr_load = 1'b1;
        st_d     = ST_GAP_ISO;
      end
      ST_GAP_ISO: if (tmr_expired) begin
        out_cmd  = RAIL_ISO;
        tmr_load = 1'b1;
        st_d     = ST_GAP_OFF;
      end
      ST_GAP_OFF: if (tmr_expired) begin
        out_cmd = RAIL_PWR_OFF;
        finish  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      active_q <= 1'b0;
      in_q     <= 1'b0;
      done_q   <= 1'b0;
      gap_q    <= MIN_GAP_V;
    end else begin
      st_q   <= st_d;
      done_q <= finish | trivial;
      if (finish) active_q <= in_q;
      if (accept) begin
        in_q  <= mig_target;
        gap_q <= (step_delay < MIN_GAP_V) ? MIN_GAP_V : step_delay;
      end
    end
  end

  cms_gap_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (gap_q - 1'b1),
    .expired  (tmr_expired)
  );

  for (genvar g = 0; g < NUM_CL; g++) begin : g_rail
    always_comb begin
      if (in_idx == 1'(g))       cl_cmd[g] = in_cmd;
      else if (out_idx == 1'(g)) cl_cmd[g] = out_cmd;
      else                       cl_cmd[g] = RAIL_HOLD;
    end

    cms_cluster_rail #(.START_ON(g == 0)) u_rail (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cl_cmd[g]),
      .pwr_o (pwr_en[g]),
      .rst_o (rst_hold[g]),
      .iso_o (iso_en[g])
    );
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/cms_checker.sv
module cms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pgood,
  input logic [1:0] running,
  input logic [1:0] pwr_en,
  input logic [1:0] rst_hold,
  input logic [1:0] iso_en,
  input logic       busy,
  input logic       done
);
  for (genvar i = 0; i < 2; i++) begin : g_cl
    localparam int J = 1 - i;

    assert_unreset_after_pgood_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_hold[i]) |-> (pwr_en[i] && $past(pgood[i])));

    assert_uniso_when_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en[i]) |-> (pwr_en[i] && !rst_hold[i]));

    assert_outbound_after_inbound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_hold[i]) |-> (pwr_en[J] && !rst_hold[J] && !iso_en[J] && $past(running[J])));

    assert_iso_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_en[i]) |-> rst_hold[i]);

    assert_off_when_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en[i]) |-> (iso_en[i] && rst_hold[i]));
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_one_live_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ($countones(pwr_en & ~rst_hold & ~iso_en) == 1));
endmodule

bind cluster_migration_sequencer cms_checker u_cms_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pgood    (pgood),
  .running  (running),
  .pwr_en   (pwr_en),
  .rst_hold (rst_hold),
  .iso_en   (iso_en),
  .busy     (busy),
  .done     (done)
);

// File: tb/cluster_migration_sequencer_bench.sv
module cluster_migration_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mig_req = 1'b0;
  logic       mig_target = 1'b0;
  logic [7:0] step_delay = 8'd4;
  logic [1:0] pgood = 2'b01;
  logic [1:0] running = 2'b01;
  logic [1:0] pwr_en, rst_hold, iso_en;
  logic       busy, done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  cluster_migration_sequencer u_cluster_migration_sequencer (
    .clk(clk), .rst_n(rst_n), .mig_req(mig_req), .mig_target(mig_target),
    .step_delay(step_delay), .pgood(pgood), .running(running),
    .pwr_en(pwr_en), .rst_hold(rst_hold), .iso_en(iso_en),
    .busy(busy), .done(done)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic test_reset_state();
    check("R1 pwr_en",   {30'd0, pwr_en},   32'h1);
    check("R1 rst_hold", {30'd0, rst_hold}, 32'h2);
    check("R1 iso_en",   {30'd0, iso_en},   32'h2);
    check("R1 busy/done", {30'd0, busy, done}, 32'h0);
  endtask

  task automatic test_same_target(input logic tgt);
    logic [5:0] snap;
    snap = {pwr_en, rst_hold, iso_en};
    mig_target = tgt; mig_req = 1'b1;
    @(negedge clk); mig_req = 1'b0;
    check("R7 done pulse", {31'd0, done}, 32'h1);
    check("R7 no busy", {31'd0, busy}, 32'h0);
    check("R7 rails unchanged", {26'd0, pwr_en, rst_hold, iso_en}, {26'd0, snap});
    @(negedge clk);
    check("R7 done drops", {31'd0, done}, 32'h0);
    check("R7 rails still unchanged", {26'd0, pwr_en, rst_hold, iso_en}, {26'd0, snap});
  endtask

  task automatic test_migration(input logic tgt, input int dly);
    logic src;
    int g, n;
    logic [5:0] snap;
    src = !tgt;
    g = (dly < 4) ? 4 : dly;
    step_delay = 8'(dly); mig_target = tgt; mig_req = 1'b1;
    @(negedge clk); mig_req = 1'b0;
    step_delay = 8'd20;
    check("R2 inbound power on", {31'd0, pwr_en[tgt]}, 32'h1);
    check("R2 busy set", {31'd0, busy}, 32'h1);
    repeat (3) @(negedge clk);
    check("R2 reset held without pgood", {31'd0, rst_hold[tgt]}, 32'h1);
    snap = {pwr_en, rst_hold, iso_en};
    mig_target = src; mig_req = 1'b1;
    @(negedge clk); mig_req = 1'b0;
    check("R8 busy request ignored", {26'd0, pwr_en, rst_hold, iso_en}, {26'd0, snap});
    check("R8 still busy", {30'd0, busy, done}, 32'h2);
    pgood[tgt] = 1'b1;
    @(negedge clk);
    check("R2 reset released", {30'd0, rst_hold[tgt], iso_en[tgt]}, 32'h1);
    n = 0;
    while (iso_en[tgt] && n < 100) begin @(negedge clk); n++; end
    check("R3 unreset-to-uniso gap", n, g);
    repeat (5) @(negedge clk);
    check("R4 outbound untouched before running",
          {28'd0, pwr_en[src], rst_hold[src], iso_en[src], busy}, 32'h9);
    running[tgt] = 1'b1;
    @(negedge clk);
    check("R4 outbound reset on running", {30'd0, rst_hold[src], iso_en[src]}, 32'h2);
    n = 0;
    while (!iso_en[src] && n < 100) begin @(negedge clk); n++; end
    check("R5 reset-to-iso gap", n, g);
    check("R5 still powered when clamped", {31'd0, pwr_en[src]}, 32'h1);
    n = 0;
    while (pwr_en[src] && n < 100) begin
      if (done) check("R6 early done", 32'h1, 32'h0);
      @(negedge clk); n++;
    end
    check("R5 iso-to-off gap", n, g);
    check("R6 done with power off", {30'd0, done, busy}, 32'h2);
    @(negedge clk);
    check("R6 done single cycle", {31'd0, done}, 32'h0);
    check("R9 only inbound live", {30'd0, pwr_en & ~rst_hold & ~iso_en},
          tgt ? 32'h2 : 32'h1);
    running[src] = 1'b0; pgood[src] = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_state();
    test_same_target(1'b0);
    test_migration(1'b1, 6);
    test_same_target(1'b1);
    test_migration(1'b0, 2);
    test_migration(1'b1, 4);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule